// File: doc/BRIEF.md
# Auto-Scan ADC Channel Sequencer

This block is the digital control core of a multi-channel converter that talks to a host over a 16-bit serial frame. A frame opens when the active-low chip select drops and carries sixteen serial clock edges. The design sees each serial falling edge as a one-cycle strobe in its own clock domain. While the frame runs, the block shifts a command word in and an output word out. When chip select rises after a full frame, it acts on the command.

Two scan behaviours exist. In hold mode the multiplexer address stays where it is. In automatic scan mode the address steps from channel 0 up to a programmed last channel and then starts again at 0. Conversion data trails the multiplexer by one frame: the word shifted out in a frame belongs to the channel the multiplexer held during the frame before it. The output word has a 12-bit result from a stub converter input in its low bits. Its top nibble is either the channel tag or a view of the four GPIO pins. Mode commands also set the input range, power-down and the GPIO output latch.

Top module: `auto_scan_seq`

## Requirements
- R1: After reset the block is in hold mode. The mux address, last channel, range, power-down, tag select and GPIO output latch are all 0.
- R2: Serial data is taken MSB first on each strobe while chip select is low, and only the first 16 bits of a frame count. A frame acts only if at least 16 strobes came before chip select rises. A shorter frame changes no state.
- R3: A command with bits 15:12 = 0011 selects automatic scan. Entering it from hold sets the mux to 0 at the end of that frame. Every later valid frame in scan moves the mux up by one. The tag in a frame's output word is the mux address held during the previous valid frame.
- R4: In scan mode, when the mux equals the last channel, the next valid frame sets it to 0.
- R5: A command with bits 15:12 = 1001 loads the last channel from bits 9:6 and ignores every other bit. In scan mode it restarts the mux at 0. It never changes range, tag select, power-down or GPIO outputs.
- R6: In a mode command (0011 or 0001), bit 11 = 1 loads bits 10:0 and bit 11 = 0 keeps the earlier settings. With bit 11 = 1, bit 10 = 1 forces the mux to 0 at the end of the frame.
- R7: With bit 11 set, a mode command takes range from bit 6 (1 = double span) at frame end. It takes power-down from bit 5 one cycle after the 16th strobe.
- R8: Output bits 11:0 are the conversion input sampled when chip select falls. Bits 15:12 are the channel tag when tag select (bit 4) is 0. When tag select is 1, bits 15:12 are the GPIO view: for each pin, the output latch bit if the pin is an output, else the pin input.
- R9: With bit 11 set, a mode command writes bits 3:0 into the GPIO output latch only for pins whose direction bit is 1. Latch bits of input pins keep their value.
- R10: A command with bits 15:12 = 0001 selects hold mode, and the mux keeps its address. Any other top code leaves the mode as it is; in scan mode it counts as a normal advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk_fall | input | 1 | One-cycle strobe per serial falling edge |
| sdi | input | 1 | Serial command bit |
| sdo | output | 1 | Serial output bit, MSB first |
| conv_result | input | 12 | Stub conversion result |
| gpio_dir | input | 4 | Pin direction, 1 = output |
| gpio_in | input | 4 | Pin input levels |
| mux_sel | output | 4 | Analog multiplexer address |
| range_dbl | output | 1 | Double-span input range |
| power_down | output | 1 | Power-down request |
| gpio_out | output | 4 | GPIO output latch |

## Verification
At the end of a frame, a restart and a normal step can both apply to the mux. This happens when a last-channel write or a bit-10 mode command lands mid-scan, and when scan mode is entered while the mux is not 0. The bench provokes each case. It expects the mux at 0, never at the stepped value, in the cycle after chip select rises. The output word of the next frame must show the channel held before the restart. A second collision is tested with a last-channel write whose other bits look like range and GPIO data. The bench then checks that range, GPIO latch and power-down do not move in that frame.

// File: rtl/auto_scan_pkg.sv
package auto_scan_pkg;

    localparam int FRAME_W = 16;
    localparam int RES_W   = 12;
    localparam int TAG_W   = FRAME_W - RES_W;
    localparam int CH_W    = 4;
    localparam int GPIO_W  = 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [3:0] OP_HOLD = 4'b0001;
    localparam logic [3:0] OP_AUTO = 4'b0011;
    localparam logic [3:0] OP_LAST = 4'b1001;

    localparam int B_LOAD    = 11;
    localparam int B_RESTART = 10;
    localparam int B_LAST_HI = 9;
    localparam int B_LAST_LO = 6;
    localparam int B_RANGE   = 6;
    localparam int B_PDN     = 5;
    localparam int B_TAGSEL  = 4;

    typedef logic [CH_W-1:0]    chan_t;
    typedef logic [GPIO_W-1:0]  gpio_t;
    typedef logic [FRAME_W-1:0] word_t;
    typedef logic [RES_W-1:0]   res_t;

    typedef enum logic {MODE_HOLD = 1'b0, MODE_AUTO = 1'b1} scan_mode_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_HOLD = 2'd1,
        CMD_AUTO = 2'd2,
        CMD_LAST = 2'd3
    } cmd_kind_t;

    typedef struct packed {
        cmd_kind_t kind;
        logic      load_cfg;
        logic      restart_req;
        logic      rng;
        logic      pdn;
        logic      tag_gpio;
        gpio_t     gpio_val;
        chan_t     last_ch;
    } cmd_t;

    function automatic chan_t next_channel(input chan_t cur, input chan_t last);
        if (cur >= last) return '0;
        return cur + chan_t'(1);
    endfunction

endpackage

// File: rtl/scan_frame_io.sv
module scan_frame_io
    import auto_scan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  bit_stb,
    input  logic  sdi,
    input  word_t load_word,
    output logic  sdo,
    output logic  frame_done,
    output logic  full_stb,
    output word_t cmd_word
);

    logic             cs_q;
    logic [CNT_W-1:0] cnt_q;
    word_t            in_sr;
    word_t            out_sr;
    logic             full_q;
    logic             start, stop, take;

    assign start = cs_q & ~cs_n;
    assign stop  = ~cs_q & cs_n;
    assign take  = ~cs_n & ~start & bit_stb & (cnt_q < CNT_W'(FRAME_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            cnt_q  <= '0;
            in_sr  <= '0;
            out_sr <= '0;
            full_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            full_q <= take & (cnt_q == CNT_W'(FRAME_W - 1));
            if (start) begin
                cnt_q  <= '0;
                out_sr <= load_word;
            end else if (take) begin
                cnt_q  <= cnt_q + CNT_W'(1);
                in_sr  <= {in_sr[FRAME_W-2:0], sdi};
                out_sr <= {out_sr[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign sdo        = out_sr[FRAME_W-1];
    assign frame_done = stop & (cnt_q == CNT_W'(FRAME_W));
    assign full_stb   = full_q;
    assign cmd_word   = in_sr;

endmodule

// File: rtl/scan_cmd_decode.sv
module scan_cmd_decode
    import auto_scan_pkg::*;
(
    input  word_t word,
    output cmd_t  cmd
);

    always_comb begin
        unique case (word[FRAME_W-1:FRAME_W-4])
            OP_HOLD: cmd.kind = CMD_HOLD;
            OP_AUTO: cmd.kind = CMD_AUTO;
            OP_LAST: cmd.kind = CMD_LAST;
            default: cmd.kind = CMD_NONE;
        endcase
        cmd.load_cfg    = word[B_LOAD];
        cmd.restart_req = word[B_LOAD] & word[B_RESTART];
        cmd.rng         = word[B_RANGE];
        cmd.pdn         = word[B_PDN];
        cmd.tag_gpio    = word[B_TAGSEL];
        cmd.gpio_val    = word[GPIO_W-1:0];
        cmd.last_ch     = word[B_LAST_HI:B_LAST_LO];
    end

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import auto_scan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_done,
    input  logic  full_stb,
    input  cmd_t  cmd,
    input  gpio_t gpio_dir,
    output chan_t mux_addr,
    output chan_t data_chan,
    output chan_t last_ch,
    output logic  mode_auto,
    output logic  range_dbl,
    output logic  power_down,
    output logic  tag_gpio,
    output gpio_t gpio_out
);

    scan_mode_t mode_q, mode_d;
    chan_t      mux_q, mux_d, last_q, last_d, data_q, adv;
    logic       rng_q, pd_q, tag_q;
    gpio_t      gpio_q, gpio_d;
    logic       cfg_we;

    always_comb begin
        adv    = next_channel(mux_q, last_q);
        mux_d  = mux_q;
        mode_d = mode_q;
        last_d = last_q;
        unique case (cmd.kind)
            CMD_AUTO: begin
                mode_d = MODE_AUTO;
                mux_d  = (mode_q != MODE_AUTO || cmd.restart_req) ? '0 : adv;
            end
            CMD_HOLD: begin
                mode_d = MODE_HOLD;
                mux_d  = cmd.restart_req ? '0 : mux_q;
            end
            CMD_LAST: begin
                last_d = cmd.last_ch;
                mux_d  = (mode_q == MODE_AUTO) ? '0 : mux_q;
            end
            default: mux_d = (mode_q == MODE_AUTO) ? adv : mux_q;
        endcase
        cfg_we = cmd.load_cfg & ((cmd.kind == CMD_AUTO) | (cmd.kind == CMD_HOLD));
        gpio_d = (gpio_q & ~gpio_dir) | (cmd.gpio_val & gpio_dir);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_HOLD;
            mux_q  <= '0;
            last_q <= '0;
            data_q <= '0;
            rng_q  <= 1'b0;
            pd_q   <= 1'b0;
            tag_q  <= 1'b0;
            gpio_q <= '0;
        end else begin
            if (frame_done) begin
                mode_q <= mode_d;
                mux_q  <= mux_d;
                last_q <= last_d;
                data_q <= mux_q;
                if (cfg_we) begin
                    rng_q  <= cmd.rng;
                    tag_q  <= cmd.tag_gpio;
                    gpio_q <= gpio_d;
                end
            end
            if (full_stb && cfg_we) pd_q <= cmd.pdn;
        end
    end

    assign mux_addr   = mux_q;
    assign data_chan  = data_q;
    assign last_ch    = last_q;
    assign mode_auto  = (mode_q == MODE_AUTO);
    assign range_dbl  = rng_q;
    assign power_down = pd_q;
    assign tag_gpio   = tag_q;
    assign gpio_out   = gpio_q;

endmodule

// File: rtl/scan_word_fmt.sv
module scan_word_fmt
    import auto_scan_pkg::*;
(
    input  chan_t data_chan,
    input  logic  tag_gpio,
    input  gpio_t gpio_dir,
    input  gpio_t gpio_out,
    input  gpio_t gpio_in,
    input  res_t  result,
    output word_t word
);

    gpio_t view;
    logic [TAG_W-1:0] tag;

    assign view = (gpio_out & gpio_dir) | (gpio_in & ~gpio_dir);
    assign tag  = tag_gpio ? view : data_chan;
    assign word = {tag, result};

endmodule

// File: rtl/auto_scan_seq.sv
module auto_scan_seq
    import auto_scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        sclk_fall,
    input  logic        sdi,
    output logic        sdo,
    input  logic [11:0] conv_result,
    input  logic [3:0]  gpio_dir,
    input  logic [3:0]  gpio_in,
    output logic [3:0]  mux_sel,
    output logic        range_dbl,
    output logic        power_down,
    output logic [3:0]  gpio_out
);

    word_t load_word, cmd_word;
    logic  frame_done, full_stb, mode_auto, tag_gpio;
    cmd_t  cmd;
    chan_t data_chan, last_ch;

    scan_frame_io u_io (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .bit_stb    (sclk_fall),
        .sdi        (sdi),
        .load_word  (load_word),
        .sdo        (sdo),
        .frame_done (frame_done),
        .full_stb   (full_stb),
        .cmd_word   (cmd_word)
    );

    scan_cmd_decode u_dec (
        .word (cmd_word),
        .cmd  (cmd)
    );

    scan_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .full_stb   (full_stb),
        .cmd        (cmd),
        .gpio_dir   (gpio_dir),
        .mux_addr   (mux_sel),
        .data_chan  (data_chan),
        .last_ch    (last_ch),
        .mode_auto  (mode_auto),
        .range_dbl  (range_dbl),
        .power_down (power_down),
        .tag_gpio   (tag_gpio),
        .gpio_out   (gpio_out)
    );

    scan_word_fmt u_fmt (
        .data_chan (data_chan),
        .tag_gpio  (tag_gpio),
        .gpio_dir  (gpio_dir),
        .gpio_out  (gpio_out),
        .gpio_in   (gpio_in),
        .result    (conv_result),
        .word      (load_word)
    );

endmodule

// File: rtl/auto_scan_seq_chk.sv
module auto_scan_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_done,
    input logic        full_stb,
    input logic [15:0] cmd_word,
    input logic        mode_auto,
    input logic [3:0]  mux_sel,
    input logic [3:0]  last_ch,
    input logic        power_down
);

    // R2: the mux address moves only at the end of a full frame
    a_r2_mux_only_at_end: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(mux_sel));

    // R4: while scanning the address never passes the last channel
    a_r4_within_last: assert property (@(posedge clk) disable iff (rst)
        mode_auto |-> (mux_sel <= last_ch));

    // R3: entry into scan restarts at channel 0
    a_r3_entry_restart: assert property (@(posedge clk) disable iff (rst)
        (frame_done && cmd_word[15:12] == 4'b0011 && !mode_auto)
        |=> (mux_sel == 4'd0 && mode_auto));

    // R3: a plain frame during scan steps by one or wraps
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (frame_done && mode_auto && cmd_word[15:12] != 4'b0011
         && cmd_word[15:12] != 4'b1001 && cmd_word[15:12] != 4'b0001)
        |=> (mux_sel == $past(mux_sel) + 4'd1 || mux_sel == 4'd0));

    // R5: a last-channel write during scan restarts at 0
    a_r5_last_restart: assert property (@(posedge clk) disable iff (rst)
        (frame_done && cmd_word[15:12] == 4'b1001 && mode_auto) |=> (mux_sel == 4'd0));

    // R7: power-down changes only right after the sixteenth strobe
    a_r7_pd_timing: assert property (@(posedge clk) disable iff (rst)
        !full_stb |=> $stable(power_down));

    // R10: hold command keeps the address unless bit 10 restarts it
    a_r10_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        (frame_done && cmd_word[15:12] == 4'b0001 && !(cmd_word[11] && cmd_word[10]))
        |=> $stable(mux_sel));

endmodule

bind auto_scan_seq auto_scan_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .full_stb   (full_stb),
    .cmd_word   (cmd_word),
    .mode_auto  (mode_auto),
    .mux_sel    (mux_sel),
    .last_ch    (last_ch),
    .power_down (power_down)
);

// File: tb/tb_auto_scan_seq.sv
`timescale 1ns/1ps
module tb_auto_scan_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk_fall = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [11:0] conv_result = '0;
    logic [3:0]  gpio_dir = 4'b0011;
    logic [3:0]  gpio_in = 4'b1010;
    logic [3:0]  mux_sel;
    logic        range_dbl;
    logic        power_down;
    logic [3:0]  gpio_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    // reference state
    bit       m_auto = 0;
    int       m_mux = 0, m_data = 0, m_last = 0;
    bit       m_rng = 0, m_pd = 0, m_tag = 0;
    bit [3:0] m_gout = 0;

    always #2 clk = ~clk;

    auto_scan_seq dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk_fall(sclk_fall), .sdi(sdi),
        .sdo(sdo), .conv_result(conv_result), .gpio_dir(gpio_dir),
        .gpio_in(gpio_in), .mux_sel(mux_sel), .range_dbl(range_dbl),
        .power_down(power_down), .gpio_out(gpio_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the reference
    always @(posedge clk) begin
        #3;
        if (cmp_on && !rst && !done) begin
            chk(mux_sel == 4'(m_mux), "R3/R4 mux address", int'(mux_sel), m_mux);
            chk(range_dbl == m_rng, "R7 range", int'(range_dbl), int'(m_rng));
            chk(power_down == m_pd, "R7 power-down", int'(power_down), int'(m_pd));
            chk(gpio_out == m_gout, "R9 gpio latch", int'(gpio_out), int'(m_gout));
        end
    end

    function automatic int step(input int cur, input int last);
        return (cur >= last) ? 0 : cur + 1;
    endfunction

    function automatic bit [15:0] expect_word(input bit [11:0] res);
        bit [3:0] t;
        if (m_tag) begin
            for (int i = 0; i < 4; i++) t[i] = gpio_dir[i] ? m_gout[i] : gpio_in[i];
        end else begin
            t = 4'(m_data);
        end
        return {t, res};
    endfunction

    task automatic model_frame_end(input bit [15:0] c);
        int nm;
        bit [3:0] op = c[15:12];
        if (op == 4'b0011) begin
            nm = (!m_auto || (c[11] && c[10])) ? 0 : step(m_mux, m_last);
            m_auto = 1;
        end else if (op == 4'b0001) begin
            nm = (c[11] && c[10]) ? 0 : m_mux;
            m_auto = 0;
        end else if (op == 4'b1001) begin
            m_last = int'(c[9:6]);
            nm = m_auto ? 0 : m_mux;
        end else begin
            nm = m_auto ? step(m_mux, m_last) : m_mux;
        end
        if ((op == 4'b0011 || op == 4'b0001) && c[11]) begin
            m_rng = c[6];
            m_tag = c[4];
            for (int i = 0; i < 4; i++) if (gpio_dir[i]) m_gout[i] = c[i];
        end
        m_data = m_mux;
        m_mux  = nm;
    endtask

    task automatic frame(input bit [15:0] c, input int nbits, input bit [11:0] res,
                         input string req);
        bit [15:0] exp_w, got;
        exp_w = expect_word(res);
        got = '0;
        @(negedge clk);
        conv_result = res;
        cs_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i < 16) got[15-i] = sdo;
            sdi = (i < 16) ? c[15-i] : 1'b0;
            sclk_fall = 1'b1;
            @(negedge clk);
            sclk_fall = 1'b0;
            if (i == 15) begin
                @(posedge clk);
                #1;
                if ((c[15:12] == 4'b0011 || c[15:12] == 4'b0001) && c[11]) m_pd = c[5];
            end
            @(negedge clk);
        end
        cs_n = 1'b1;
        sdi = 1'b0;
        @(posedge clk);
        #1;
        if (nbits >= 16) begin
            model_frame_end(c);
            chk(got == exp_w, req, int'(got), int'(exp_w));
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(mux_sel == 4'd0, "R1 mux at reset", int'(mux_sel), 0);
        chk(range_dbl == 1'b0, "R1 range at reset", int'(range_dbl), 0);
        chk(power_down == 1'b0, "R1 power-down at reset", int'(power_down), 0);
        chk(gpio_out == 4'd0, "R1 gpio at reset", int'(gpio_out), 0);
        cmp_on = 1'b1;

        // R1/R8: first word shows channel 0 tag; R10 no-op in hold
        frame(16'h0000, 16, 12'h5A1, "R1 R8 first word");
        frame(16'h0000, 16, 12'h5A2, "R10 hold no-op word");
        // R5: last channel = 2, junk elsewhere ignored
        frame(16'h9CBF, 16, 12'h5A3, "R5 last write word");
        // R3: enter scan with range, gpio write (R9 masks pins 3:2)
        frame(16'h384F, 16, 12'h5A4, "R3 entry word");
        for (int k = 0; k < 6; k++) frame(16'h0000, 16, 12'h600 + 12'(k), "R3 R4 scan word");
        // R2: short frame has no effect
        frame(16'h9000, 8, 12'h611, "R2 short frame");
        frame(16'h0000, 16, 12'h612, "R2 after short frame word");
        // R2: long frame uses first 16 bits
        frame(16'h0000, 20, 12'h613, "R2 long frame word");
        // R5: rewrite last channel mid-scan restarts, other fields ignored
        frame(16'h917F, 16, 12'h620, "R5 mid-scan rewrite word");
        frame(16'h0000, 16, 12'h621, "R5 restart pipeline word");
        // R6: bit 11 clear keeps config, no restart
        frame(16'h307F, 16, 12'h630, "R6 keep config word");
        frame(16'h0000, 16, 12'h631, "R6 advance word");
        // R6: restart via bit 10, tag select GPIO, range back to single
        frame(16'h3C10, 16, 12'h640, "R6 restart word");
        frame(16'h0000, 16, 12'h641, "R8 gpio tag word");
        // R9: gpio write with input pins masked
        frame(16'h381F, 16, 12'h650, "R9 gpio write word");
        frame(16'h0000, 16, 12'h651, "R8 R9 gpio view word");
        // R7: power-down on and off
        frame(16'h3820, 16, 12'h660, "R7 pd on word");
        frame(16'h3800, 16, 12'h661, "R7 pd off word");
        for (int k = 0; k < 3; k++) frame(16'h0000, 16, 12'h670 + 12'(k), "R3 scan word");
        // R10: hold keeps address
        frame(16'h1000, 16, 12'h680, "R10 hold entry word");
        for (int k = 0; k < 3; k++) frame(16'h0000, 16, 12'h690 + 12'(k), "R10 held word");
        // R5: last write in hold does not move mux
        frame(16'h9100, 16, 12'h6A0, "R5 write in hold word");
        // R3: re-enter scan (bit 11 clear), then wrap at last=4
        frame(16'h3000, 16, 12'h6B0, "R3 re-entry word");
        for (int k = 0; k < 7; k++) frame(16'h0000, 16, 12'h6C0 + 12'(k), "R4 wrap word");
        // R10: unknown opcode advances in scan
        frame(16'h7000, 16, 12'h6D0, "R10 other code word");
        frame(16'h0000, 16, 12'h6D1, "R10 other code follow word");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule